// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block collects fifteen peripheral interrupt request lines and decides which one the processor core services next. Each line has a pending bit, set on a rising edge of the line or by a software force write, and a mask bit. A request is eligible only when both bits are 1. Each source also has a programmable priority level that is separate from its ID. Several sources may share a level.

A three-state sequencer presents the best eligible request to the core as `irq_out` with an ID on `irq_id`. The states are `S_IDLE` (no request), `S_REQ` (request shown) and `S_GAP` (one quiet cycle after an acknowledge).

- `S_IDLE -> S_REQ` when a request qualifies.
- `S_REQ -> S_REQ` while it still qualifies; the ID follows the current best.
- `S_REQ -> S_IDLE` when it no longer qualifies (withdraw).
- `S_REQ -> S_GAP` on acknowledge.
- `S_GAP -> S_IDLE` always.

An acknowledge moves the shown source from pending to in-service. A return pulse retires the highest-priority in-service source. A control register holds a global enable and a nesting enable. With nesting off, sources are served one after another. With nesting on, only a strictly higher priority may preempt the source in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, pending, mask and in-service bits and the control register are all zero, so servicing is disabled and `irq_out` is 0. Source k has priority k for k below 11; sources 11 to 14 have priority 11.
- R2: A 0-to-1 transition on `src_req[k]` sets pending bit k one clock later. A line held high does not set the bit again after it has been cleared.
- R3: A write to address 2 sets every pending bit whose data bit is 1. A write to address 3 clears every pending bit whose data bit is 1. When a set and a clear of the same bit fall in one cycle, the set wins. Address 2 reads the pending bits.
- R4: A pending source is eligible only when its mask bit (address 1, bit k) is 1. A masked source is never requested.
- R5: Among eligible sources, the one with the lowest priority value is chosen, and on a tie the lowest ID wins.
- R6: `irq_out` is 1 only if the global enable (control bit 5) was 1 in the previous cycle. `dis_int` clears the global enable and `ena_int` sets it. `dis_int` beats `ena_int`, and both beat a control write.
- R7: The control register is at address 0. Bit 4 enables nesting and bit 5 is the global enable. All other bits read as zero.
- R8: While `irq_out` is 1, `irq_ack` clears pending bit `irq_id` and sets in-service bit `irq_id` (address 3 reads the in-service bits). `irq_out` is 0 in the next cycle.
- R9: With nesting disabled, no request is raised while any in-service bit is set.
- R10: With nesting enabled, a request is raised only if the best eligible priority value is strictly lower than that of the highest-priority in-service source.
- R11: `irq_ret` clears the in-service bit of the highest-priority in-service source, with ties going to the lowest ID.
- R12: The priority fields sit at addresses 4 to 7, four 4-bit fields per address. Source k is at address 4 + k/4, bits [4*(k%4)+3 : 4*(k%4)]. Unused field bits read as zero. All fields are writable and read back.
- R13: `irq_out` rises two clocks after a rising edge on a request line: one clock to latch pending and one for the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 15 | Peripheral request lines, edge-latched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| ena_int | input | 1 | Global enable pulse |
| dis_int | input | 1 | Global disable pulse |
| irq_out | output | 1 | Interrupt request to the core |
| irq_id | output | 4 | ID of the requested source, valid while `irq_out` is 1 |
| irq_ack | input | 1 | Core acknowledge of the shown request |
| irq_ret | input | 1 | Core return-from-interrupt pulse |

## Verification
The bench builds the block with its default values: fifteen sources, 4-bit priority fields and 16-bit registers. With these values the last priority register is only partly filled, so its unused field reading zero can be checked. The four sources that share level 11 at reset also give a real tie to break by ID. Four-bit fields leave room to reprogram two sources onto equal or reversed levels, which makes the strict-preemption rule and tie-breaking under nesting visible at the ports.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_GAP  = 2'd2
    } seq_state_e;

    // register addresses
    localparam int A_CTRL  = 0;
    localparam int A_MASK  = 1;
    localparam int A_PEND  = 2;
    localparam int A_CLR   = 3;
    localparam int A_PRIO0 = 4;

    // control bit positions
    localparam int CTL_NEST_BIT = 4;
    localparam int CTL_GIE_BIT  = 5;

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int N_SRC = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] force_set,
    input  logic [N_SRC-1:0] force_clr,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] pend_q
);
    logic [N_SRC-1:0] src_d;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] pend_n;

    always_comb begin
        rise   = src_req & ~src_d;
        // new set events win over clears in the same cycle
        pend_n = (pend_q & ~force_clr & ~ack_clr) | rise | force_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_d  <= '0;
            pend_q <= '0;
        end else begin
            src_d  <= src_req;
            pend_q <= pend_n;
        end
    end
endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick #(
    parameter int N_SRC  = 15,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    found,
    output logic [ID_W-1:0]         best_id,
    output logic [PRIO_W-1:0]       best_prio
);
    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '0;
        // strict compare keeps the lowest ID on equal levels
        for (int k = 0; k < N_SRC; k++) begin
            if (cand[k] && (!found || (prio_flat[k*PRIO_W +: PRIO_W] < best_prio))) begin
                found     = 1'b1;
                best_id   = ID_W'(k);
                best_prio = prio_flat[k*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_prio_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            qualify,
    input  logic [ID_W-1:0] best_id,
    input  logic            irq_ack,
    output logic            irq_out,
    output logic [ID_W-1:0] irq_id,
    output logic            ack_fire
);
    seq_state_e      state_q, state_n;
    logic [ID_W-1:0] id_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (qualify) state_n = S_REQ;
            S_REQ: begin
                if (irq_ack)       state_n = S_GAP;
                else if (!qualify) state_n = S_IDLE;
                else               state_n = S_REQ;
            end
            S_GAP:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_n;
            if (state_n == S_REQ) id_q <= best_id;
        end
    end

    // outputs
    always_comb begin
        irq_out  = (state_q == S_REQ);
        irq_id   = id_q;
        ack_fire = (state_q == S_REQ) && irq_ack;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N_SRC      = 15,
    parameter int PRIO_W     = 4,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 3,
    parameter int SHARED_LVL = 11,
    localparam int ID_W      = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ena_int,
    input  logic              dis_int,
    output logic              irq_out,
    output logic [ID_W-1:0]   irq_id,
    input  logic              irq_ack,
    input  logic              irq_ret
);
    localparam int FPR = DATA_W / PRIO_W;
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
    localparam logic [ADDR_W-1:0] AD_PEND = ADDR_W'(A_PEND);
    localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);

    logic                    gie_q, nest_q;
    logic [N_SRC-1:0]        mask_q, pend_q, isr_q;
    logic [PRIO_W-1:0]       prio_q [N_SRC];
    logic [N_SRC*PRIO_W-1:0] prio_flat;

    logic [N_SRC-1:0] force_set, force_clr, ack_vec, ret_vec;
    logic             elig_found, isr_found, qualify, ack_fire;
    logic [ID_W-1:0]  elig_id, isr_id;
    logic [PRIO_W-1:0] elig_prio, isr_prio;
    logic              wr_ctrl, wr_mask;

    assign wr_ctrl   = reg_wr && (reg_addr == AD_CTRL);
    assign wr_mask   = reg_wr && (reg_addr == AD_MASK);
    assign force_set = (reg_wr && reg_addr == AD_PEND) ? reg_wdata[N_SRC-1:0] : '0;
    assign force_clr = (reg_wr && reg_addr == AD_CLR)  ? reg_wdata[N_SRC-1:0] : '0;

    // control and mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            nest_q <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) nest_q <= reg_wdata[CTL_NEST_BIT];
            if (dis_int)      gie_q <= 1'b0;
            else if (ena_int) gie_q <= 1'b1;
            else if (wr_ctrl) gie_q <= reg_wdata[CTL_GIE_BIT];
            if (wr_mask) mask_q <= reg_wdata[N_SRC-1:0];
        end
    end

    // per-source priority fields
    for (genvar k = 0; k < N_SRC; k++) begin : g_prio
        localparam logic [ADDR_W-1:0] AD_FLD = ADDR_W'(A_PRIO0 + k / FPR);
        localparam int                BASE   = (k % FPR) * PRIO_W;
        localparam logic [PRIO_W-1:0] RST_LV = PRIO_W'((k < SHARED_LVL) ? k : SHARED_LVL);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             prio_q[k] <= RST_LV;
            else if (reg_wr && reg_addr == AD_FLD)  prio_q[k] <= reg_wdata[BASE +: PRIO_W];
        end
        assign prio_flat[k*PRIO_W +: PRIO_W] = prio_q[k];
    end

    irq_pend_latch #(.N_SRC(N_SRC)) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .force_set (force_set),
        .force_clr (force_clr),
        .ack_clr   (ack_vec),
        .pend_q    (pend_q)
    );

    irq_best_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) pick_elig_i (
        .cand      (pend_q & mask_q),
        .prio_flat (prio_flat),
        .found     (elig_found),
        .best_id   (elig_id),
        .best_prio (elig_prio)
    );

    irq_best_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) pick_isr_i (
        .cand      (isr_q),
        .prio_flat (prio_flat),
        .found     (isr_found),
        .best_id   (isr_id),
        .best_prio (isr_prio)
    );

    assign qualify = gie_q && elig_found &&
                     (!isr_found || (nest_q && (elig_prio < isr_prio)));

    irq_seq_fsm #(.ID_W(ID_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .qualify  (qualify),
        .best_id  (elig_id),
        .irq_ack  (irq_ack),
        .irq_out  (irq_out),
        .irq_id   (irq_id),
        .ack_fire (ack_fire)
    );

    assign ack_vec = ack_fire ? (N_SRC'(1) << irq_id) : '0;
    assign ret_vec = (irq_ret && isr_found) ? (N_SRC'(1) << isr_id) : '0;

    // in-service tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~ret_vec) | ack_vec;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AD_CTRL: begin
                reg_rdata[CTL_NEST_BIT] = nest_q;
                reg_rdata[CTL_GIE_BIT]  = gie_q;
            end
            AD_MASK: reg_rdata[N_SRC-1:0] = mask_q;
            AD_PEND: reg_rdata[N_SRC-1:0] = pend_q;
            AD_CLR:  reg_rdata[N_SRC-1:0] = isr_q;
            default: begin
                for (int k = 0; k < N_SRC; k++) begin
                    if (reg_addr == ADDR_W'(A_PRIO0 + k / FPR))
                        reg_rdata[(k % FPR) * PRIO_W +: PRIO_W] = prio_q[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int N_SRC = 15,
    parameter int ID_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic             irq_ack,
    input logic             irq_ret,
    input logic [ID_W-1:0]  irq_id,
    input logic             gie,
    input logic             nest,
    input logic [N_SRC-1:0] isr
);
    // R6
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(gie));

    // R8
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_ack) |=> !irq_out);

    // R8
    ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_ack) |=> isr[$past(irq_id)]);

    // R9
    seq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !$past(nest)) |-> ($past(isr) == '0));

    // R11
    ret_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && (isr != '0) && !(irq_out && irq_ack))
            |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .irq_ack (irq_ack),
    .irq_ret (irq_ret),
    .irq_id  (irq_id),
    .gie     (gie_q),
    .nest    (nest_q),
    .isr     (isr_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int N     = 15;
    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ena_int = 1'b0, dis_int = 1'b0;
    logic          irq_out;
    logic [IW-1:0] irq_id;
    logic          irq_ack = 1'b0, irq_ret = 1'b0;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ena_int(ena_int), .dis_int(dis_int),
        .irq_out(irq_out), .irq_id(irq_id), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_pend = '0, m_mask = '0, m_isr = '0, m_prev = '0;
    int           m_prio [N];
    bit           m_gie = 0, m_nest = 0;
    int           m_st = 0;   // 0 idle, 1 requesting, 2 quiet
    int           m_id = 0;

    task automatic pick(input logic [N-1:0] v, output bit f, output int id, output int pr);
        f = 0; id = 0; pr = 99;
        for (int k = 0; k < N; k++)
            if (v[k] && m_prio[k] < pr) begin f = 1; id = k; pr = m_prio[k]; end
    endtask

    function automatic logic [DW-1:0] m_read(input int a);
        logic [DW-1:0] r = '0;
        case (a)
            0: begin r[4] = m_nest; r[5] = m_gie; end
            1: r[N-1:0] = m_mask;
            2: r[N-1:0] = m_pend;
            3: r[N-1:0] = m_isr;
            default:
                for (int k = 0; k < N; k++)
                    if (4 + k / 4 == a) r[(k % 4) * 4 +: 4] = 4'(m_prio[k]);
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_isr = '0; m_prev = '0;
            m_gie = 0; m_nest = 0; m_st = 0; m_id = 0;
            for (int k = 0; k < N; k++) m_prio[k] = (k < 11) ? k : 11;
        end else begin
            bit ef, sf, qual, ackf;
            int eid, ep, sid, sp, nst, nid;
            logic [N-1:0] np, ni, setv, clrv;
            pick(m_pend & m_mask, ef, eid, ep);
            pick(m_isr, sf, sid, sp);
            qual = m_gie && ef && (!sf || (m_nest && ep < sp));
            ackf = (m_st == 1) && irq_ack;
            setv = (src_req & ~m_prev) | ((reg_wr && reg_addr == 2) ? reg_wdata[N-1:0] : '0);
            clrv = (reg_wr && reg_addr == 3) ? reg_wdata[N-1:0] : '0;
            np = m_pend & ~clrv;
            ni = m_isr;
            if (irq_ret && sf) ni[sid] = 1'b0;
            if (ackf) begin np[m_id] = 1'b0; ni[m_id] = 1'b1; end
            np = np | setv;
            nst = m_st; nid = m_id;
            case (m_st)
                0: if (qual) begin nst = 1; nid = eid; end
                1: if (ackf) nst = 2; else if (qual) nid = eid; else nst = 0;
                default: nst = 0;
            endcase
            if (reg_wr && reg_addr == 0) begin m_nest = reg_wdata[4]; m_gie = reg_wdata[5]; end
            if (ena_int) m_gie = 1;
            if (dis_int) m_gie = 0;
            if (reg_wr && reg_addr == 1) m_mask = reg_wdata[N-1:0];
            if (reg_wr && reg_addr >= 4)
                for (int k = 0; k < N; k++)
                    if (4 + k / 4 == int'(reg_addr)) m_prio[k] = int'(reg_wdata[(k % 4) * 4 +: 4]);
            m_prev = src_req; m_pend = np; m_isr = ni; m_st = nst; m_id = nid;
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (irq_out !== (m_st == 1)) begin
                bad++; $display("FAIL %s/R13 irq_out got %0d exp %0d", cur_req, irq_out, m_st == 1);
            end
            if (m_st == 1) begin
                total++;
                if (int'(irq_id) != m_id) begin
                    bad++; $display("FAIL %s/R5 irq_id got %0d exp %0d", cur_req, irq_id, m_id);
                end
            end
            total++;
            if (reg_rdata !== m_read(int'(reg_addr))) begin
                bad++; $display("FAIL %s/R12 rdata@%0d got %h exp %h", cur_req, reg_addr, reg_rdata, m_read(int'(reg_addr)));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++; $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        reg_addr = AW'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse_ack();  irq_ack = 1; tick(); irq_ack = 0; endtask
    task automatic pulse_ret();  irq_ret = 1; tick(); irq_ret = 0; endtask

    initial begin
        #(CLK_P * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state and default levels
        cur_req = "R1";
        chk("R1 irq_out", int'(irq_out), 0);
        rd(0, 'h0000, "R1 ctrl");
        rd(1, 'h0000, "R1 mask");
        rd(2, 'h0000, "R1 pend");
        rd(3, 'h0000, "R1 isr");
        rd(4, 'h3210, "R1 prio0-3");
        rd(5, 'h7654, "R1 prio4-7");
        rd(6, 'hBA98, "R1 prio8-11");
        rd(7, 'h0BBB, "R12 prio12-14 unused zero");

        // R7 reserved control bits
        cur_req = "R7";
        wr(0, 'hFFFF); rd(0, 'h0030, "R7 ctrl reserved");
        wr(0, 'h0000); rd(0, 'h0000, "R7 ctrl clear");

        // R12 priority readback
        cur_req = "R12";
        wr(5, 'h1234); rd(5, 'h1234, "R12 prio write");
        wr(5, 'h7654);

        // R2 edge latching
        cur_req = "R2";
        src_req[3] = 1; tick(); src_req[3] = 0;
        rd(2, 'h0008, "R2 pulse latched");
        src_req[5] = 1; tick();
        rd(2, 'h0028, "R2 level latched");
        wr(3, 'h0020); tick(2);
        rd(2, 'h0008, "R2 held level no relatch");
        src_req[5] = 0;

        // R3 force and clear
        cur_req = "R3";
        wr(2, 'h0101); rd(2, 'h0109, "R3 force set");
        src_req[3] = 1; wr(3, 'h0008); src_req[3] = 0;
        rd(2, 'h0109, "R3 set beats clear");
        wr(3, 'h7FFF); rd(2, 'h0000, "R3 clear all");

        // R4 masking and R5 selection
        cur_req = "R4";
        wr(2, 'h0084); wr(1, 'h0080);
        ena_int = 1; tick(); ena_int = 0;
        tick();
        chk("R4 masked src2 skipped", int'(irq_id), 7);
        chk("R4 irq_out", int'(irq_out), 1);
        cur_req = "R5";
        wr(1, 'h0084); tick();
        chk("R5 higher level chosen", int'(irq_id), 2);

        // R6 global enable
        cur_req = "R6";
        dis_int = 1; tick(); dis_int = 0; tick();
        chk("R6 disable drops request", int'(irq_out), 0);
        dis_int = 1; wr(0, 'h0020); dis_int = 0;
        rd(0, 'h0000, "R6 disable beats write");
        ena_int = 1; tick(); ena_int = 0; tick();
        chk("R6 reenabled", int'(irq_out), 1);

        // R8 acknowledge
        cur_req = "R8";
        pulse_ack();
        chk("R8 gap after ack", int'(irq_out), 0);
        rd(3, 'h0004, "R8 isr set");
        rd(2, 'h0080, "R8 pend cleared");

        // R9 no nesting
        cur_req = "R9";
        tick(3);
        chk("R9 held while in service", int'(irq_out), 0);

        // R11 return
        cur_req = "R11";
        pulse_ret();
        rd(3, 'h0000, "R11 isr cleared");
        tick();
        chk("R11 next served", int'(irq_id), 7);
        pulse_ack();
        rd(3, 'h0080, "R8 isr 7");

        // R10 nesting
        cur_req = "R10";
        wr(0, 'h0030); wr(1, 'h7FFF);
        wr(2, 'h0200); tick(2);
        chk("R10 lower level no preempt", int'(irq_out), 0);
        wr(2, 'h0002); tick();
        chk("R10 preempt", int'(irq_id), 1);
        pulse_ack();
        wr(2, 'h0001); tick();
        chk("R10 second preempt", int'(irq_id), 0);
        pulse_ack();
        rd(3, 'h0083, "R10 isr stack");
        cur_req = "R11";
        pulse_ret(); rd(3, 'h0082, "R11 top retired");
        pulse_ret(); rd(3, 'h0080, "R11 next retired");
        cur_req = "R10";
        wr(5, 'h7657); wr(2, 'h0010); tick(2);
        chk("R10 equal level no preempt", int'(irq_out), 0);
        pulse_ret(); tick();
        chk("R5 level over id", int'(irq_id), 4);

        // R5 shared level tie
        cur_req = "R5";
        wr(3, 'h7FFF); wr(2, 'h7000); tick();
        chk("R5 tie lowest id", int'(irq_id), 12);
        wr(7, 'h0BAB); tick();
        chk("R12 reprogram level", int'(irq_id), 13);

        // R13 latency
        cur_req = "R13";
        wr(3, 'h7FFF); tick(2);
        src_req[10] = 1; tick(); src_req[10] = 0;
        chk("R13 not yet", int'(irq_out), 0);
        tick();
        chk("R13 raised", int'(irq_out), 1);
        chk("R13 id", int'(irq_id), 10);
        tick(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule